// File: doc/BRIEF.md
# DMA Address Remap Router

This block sits between a DMA engine's AXI-style master and three downstream targets: a static-memory port, a DRAM port and the processor's coherency port. Every read or write address is classified by range. The low region is everything below 0x2000_0000. The high region is everything from 0x8000_0000 upward. A 2-bit remap field then decides whether the transaction goes to its normal target or is redirected to the coherency port. Addresses that fall in neither region are answered inside the block with a decode error.

The read and write channels are separate. Each channel takes one address, latches its destination at the address handshake, and keeps that route until the response has come back. Write data goes only to the latched destination. The router clears write-strobe byte lanes according to a configurable mask. Traffic bound for the coherency port carries user sideband bits, which are sampled from configuration inputs at the address handshake.

Top module: `dma_remap_router`

## Requirements
- R1: A low-region address (below 0x2000_0000) goes to port index 0 (static memory) when remap bit 1 is 0. It goes to port index 2 (coherency) when remap bit 1 is 1.
- R2: A high-region address (0x8000_0000 and above) goes to port index 1 (DRAM) when remap bit 0 is 0. It goes to port index 2 when remap bit 0 is 1.
- R3: An address in neither region raises no downstream valid. For a write, all data beats are accepted and one B response with code 2'b11 (decode error) is returned. For a read, len+1 beats are returned, each with code 2'b11 and zero data, and the last flag is set on the final beat only.
- R4: Each forwarded write strobe equals the master strobe ANDed with the inverse of the 8-bit mask, so a mask bit of 1 clears that byte lane.
- R5: The awuser and aruser outputs carry the 6-bit configuration value sampled at the address handshake when the route is the coherency port. They are zero for the other routes.
- R6: The route is fixed at the address handshake. A later change to the remap field or the user configuration does not alter a transaction already accepted. Each channel accepts no new address until the B response, or the final R beat, of its current transaction has completed.
- R7: W beats, B responses and R beats are exchanged only with the latched destination. Valid signals from other ports are ignored, and their ready signals stay low.
- R8: The read and write channels operate independently. A read can be accepted and completed while a write is partway through.
- R9: After reset, every downstream valid and both upstream response valids are low, and both upstream address-ready signals are high.
- R10: The address, burst length and write data are forwarded unchanged. A downstream address valid and its address stay steady until the target accepts them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_remap | input | 2 | Remap field; bit 1 redirects the low region, bit 0 the high region |
| cfg_strb_mask | input | 8 | Byte-lane mask; 1 clears the lane |
| cfg_awuser | input | 6 | Write user sideband for coherency traffic |
| cfg_aruser | input | 6 | Read user sideband for coherency traffic |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Master write address ready |
| s_awaddr | input | 32 | Master write address |
| s_awlen | input | 8 | Master write burst length minus one |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Master write data ready |
| s_wdata | input | 64 | Master write data |
| s_wstrb | input | 8 | Master write strobes |
| s_wlast | input | 1 | Master last write beat |
| s_bvalid | output | 1 | Write response valid to master |
| s_bready | input | 1 | Master write response ready |
| s_bresp | output | 2 | Write response code to master |
| s_arvalid | input | 1 | Master read address valid |
| s_arready | output | 1 | Master read address ready |
| s_araddr | input | 32 | Master read address |
| s_arlen | input | 8 | Master read burst length minus one |
| s_rvalid | output | 1 | Read data valid to master |
| s_rready | input | 1 | Master read data ready |
| s_rdata | output | 64 | Read data to master |
| s_rresp | output | 2 | Read response code to master |
| s_rlast | output | 1 | Last read beat to master |
| m_awvalid | output | 3 | Per-port write address valid (0 static, 1 DRAM, 2 coherency) |
| m_awready | input | 3 | Per-port write address ready |
| m_awaddr | output | 32 | Shared forwarded write address |
| m_awlen | output | 8 | Shared forwarded write length |
| m_awuser | output | 6 | Write user sideband |
| m_wvalid | output | 3 | Per-port write data valid |
| m_wready | input | 3 | Per-port write data ready |
| m_wdata | output | 64 | Shared forwarded write data |
| m_wstrb | output | 8 | Shared masked write strobes |
| m_wlast | output | 1 | Shared last write beat |
| m_bvalid | input | 3 | Per-port write response valid |
| m_bready | output | 3 | Per-port write response ready |
| m_bresp | input | 3x2 | Per-port write response code |
| m_arvalid | output | 3 | Per-port read address valid |
| m_arready | input | 3 | Per-port read address ready |
| m_araddr | output | 32 | Shared forwarded read address |
| m_arlen | output | 8 | Shared forwarded read length |
| m_aruser | output | 6 | Read user sideband |
| m_rvalid | input | 3 | Per-port read data valid |
| m_rready | output | 3 | Per-port read data ready |
| m_rdata | input | 3x64 | Per-port read data |
| m_rresp | input | 3x2 | Per-port read response code |
| m_rlast | input | 3 | Per-port last read beat |

## Verification
The bench checks the exact region edges: 0x1FFF_FFFF against 0x2000_0000, and 0x7FFF_FFFF against 0x8000_0000, under all four remap values. An off-by-one compare would send an edge address to the wrong port, or would answer a valid DRAM access with a decode error.

Some transactions flip the remap and user configuration right after the address handshake. A design that decoded combinationally from live configuration would then move W beats or responses to another port in mid-flight. Stray valids with different codes are driven on unselected ports. A router that merged responses without its latched route would pass on the wrong code or an early last flag.

Decode-error reads of up to eight beats, and a read completed while a write is stalled between its address and data phases, expose faults in beat counting and channel coupling.

// File: rtl/dmarr_pkg.sv
`timescale 1ns/1ps
package dmarr_pkg;
   typedef enum logic [1:0] {
      DST_SMEM = 2'd0,
      DST_DRAM = 2'd1,
      DST_COH  = 2'd2,
      DST_NONE = 2'd3
   } dst_e;

   localparam int unsigned NUM_DST = 3;
   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_DECERR = 2'b11;
endpackage

// File: rtl/dmarr_decode.sv
`timescale 1ns/1ps
module dmarr_decode
   import dmarr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter logic [63:0] STATIC_END = 64'h2000_0000,
   parameter logic [63:0] DRAM_BASE  = 64'h8000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        remap,
   output dst_e              dst
);
   logic [63:0] addr_ext;
   logic        in_low, in_high;

   assign addr_ext = 64'(addr);
   assign in_low   = addr_ext <  STATIC_END;
   assign in_high  = addr_ext >= DRAM_BASE;

   always_comb begin
      if (in_low)       dst = remap[1] ? DST_COH : DST_SMEM;
      else if (in_high) dst = remap[0] ? DST_COH : DST_DRAM;
      else              dst = DST_NONE;
   end
endmodule

// File: rtl/dmarr_wr.sv
`timescale 1ns/1ps
module dmarr_wr
   import dmarr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned USER_W     = 6,
   parameter logic [63:0] STATIC_END = 64'h2000_0000,
   parameter logic [63:0] DRAM_BASE  = 64'h8000_0000,
   localparam int unsigned STRB_W    = DATA_W / 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               cfg_remap,
   input  logic [STRB_W-1:0]        cfg_strb_mask,
   input  logic [USER_W-1:0]        cfg_awuser,
   input  logic                     s_awvalid,
   output logic                     s_awready,
   input  logic [ADDR_W-1:0]        s_awaddr,
   input  logic [LEN_W-1:0]         s_awlen,
   input  logic                     s_wvalid,
   output logic                     s_wready,
   input  logic [DATA_W-1:0]        s_wdata,
   input  logic [STRB_W-1:0]        s_wstrb,
   input  logic                     s_wlast,
   output logic                     s_bvalid,
   input  logic                     s_bready,
   output logic [1:0]               s_bresp,
   output logic [NUM_DST-1:0]       m_awvalid,
   input  logic [NUM_DST-1:0]       m_awready,
   output logic [ADDR_W-1:0]        m_awaddr,
   output logic [LEN_W-1:0]         m_awlen,
   output logic [USER_W-1:0]        m_awuser,
   output logic [NUM_DST-1:0]       m_wvalid,
   input  logic [NUM_DST-1:0]       m_wready,
   output logic [DATA_W-1:0]        m_wdata,
   output logic [STRB_W-1:0]        m_wstrb,
   output logic                     m_wlast,
   input  logic [NUM_DST-1:0]       m_bvalid,
   output logic [NUM_DST-1:0]       m_bready,
   input  logic [NUM_DST-1:0][1:0]  m_bresp
);
   typedef enum logic [1:0] {W_IDLE, W_ADDR, W_DATA, W_RESP} wst_e;

   wst_e                st_q;
   dst_e                dst_d, dst_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [LEN_W-1:0]    len_q;
   logic [USER_W-1:0]   user_q;
   logic [NUM_DST-1:0]  sel;
   logic                to_err;
   logic [1:0]          bresp_sel;

   dmarr_decode #(.ADDR_W(ADDR_W), .STATIC_END(STATIC_END), .DRAM_BASE(DRAM_BASE)) u_dec (
      .addr(s_awaddr), .remap(cfg_remap), .dst(dst_d)
   );

   assign to_err = (dst_q == DST_NONE);

   for (genvar p = 0; p < NUM_DST; p++) begin : g_port
      assign sel[p]       = (dst_q == dst_e'(2'(p)));
      assign m_awvalid[p] = sel[p] && (st_q == W_ADDR);
      assign m_wvalid[p]  = sel[p] && (st_q == W_DATA) && s_wvalid;
      assign m_bready[p]  = sel[p] && (st_q == W_RESP) && s_bready;
   end

   always_comb begin
      bresp_sel = RESP_OKAY;
      for (int p = 0; p < NUM_DST; p++)
         if (sel[p]) bresp_sel = m_bresp[p];
   end

   assign s_awready = (st_q == W_IDLE);
   assign s_wready  = (st_q == W_DATA) && (to_err || |(m_wready & sel));
   assign s_bvalid  = (st_q == W_RESP) && (to_err || |(m_bvalid & sel));
   assign s_bresp   = to_err ? RESP_DECERR : bresp_sel;

   assign m_awaddr  = addr_q;
   assign m_awlen   = len_q;
   assign m_awuser  = user_q;
   assign m_wdata   = s_wdata;
   assign m_wstrb   = s_wstrb & ~cfg_strb_mask;
   assign m_wlast   = s_wlast;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= W_IDLE;
         dst_q  <= DST_NONE;
         addr_q <= '0;
         len_q  <= '0;
         user_q <= '0;
      end else begin
         case (st_q)
            W_IDLE: if (s_awvalid) begin
               dst_q  <= dst_d;
               addr_q <= s_awaddr;
               len_q  <= s_awlen;
               user_q <= (dst_d == DST_COH) ? cfg_awuser : '0;
               st_q   <= (dst_d == DST_NONE) ? W_DATA : W_ADDR;
            end
            W_ADDR: if (|(m_awready & sel)) st_q <= W_DATA;
            W_DATA: if (s_wvalid && s_wready && s_wlast) st_q <= W_RESP;
            W_RESP: if (s_bvalid && s_bready) st_q <= W_IDLE;
            default: st_q <= W_IDLE;
         endcase
      end
   end

   // R6: one write in flight
   a_r6_aw_single: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_awready) |=> !s_awready);
   // R10: held address until accepted
   a_r10_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((|m_awvalid) && !(|(m_awvalid & m_awready))) |=> ($stable(m_awvalid) && $stable(m_awaddr)));
   // R7: at most one destination active
   a_r7_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_awvalid) && $onehot0(m_wvalid) && $onehot0(m_bready));
   // R4: masked lanes never reach a target
   a_r4_strb_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (|m_wvalid) |-> ((m_wstrb & cfg_strb_mask) == '0));
   // R3: an internally generated write response is a decode error
   a_r3_wr_decerr: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !(|m_bvalid)) |-> (s_bresp == RESP_DECERR));
   // R5: no sideband on direct routes
   a_r5_awuser_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid[0] || m_awvalid[1]) |-> (m_awuser == '0));
endmodule

// File: rtl/dmarr_rd.sv
`timescale 1ns/1ps
module dmarr_rd
   import dmarr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned USER_W     = 6,
   parameter logic [63:0] STATIC_END = 64'h2000_0000,
   parameter logic [63:0] DRAM_BASE  = 64'h8000_0000
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    cfg_remap,
   input  logic [USER_W-1:0]             cfg_aruser,
   input  logic                          s_arvalid,
   output logic                          s_arready,
   input  logic [ADDR_W-1:0]             s_araddr,
   input  logic [LEN_W-1:0]              s_arlen,
   output logic                          s_rvalid,
   input  logic                          s_rready,
   output logic [DATA_W-1:0]             s_rdata,
   output logic [1:0]                    s_rresp,
   output logic                          s_rlast,
   output logic [NUM_DST-1:0]            m_arvalid,
   input  logic [NUM_DST-1:0]            m_arready,
   output logic [ADDR_W-1:0]             m_araddr,
   output logic [LEN_W-1:0]              m_arlen,
   output logic [USER_W-1:0]             m_aruser,
   input  logic [NUM_DST-1:0]            m_rvalid,
   output logic [NUM_DST-1:0]            m_rready,
   input  logic [NUM_DST-1:0][DATA_W-1:0] m_rdata,
   input  logic [NUM_DST-1:0][1:0]       m_rresp,
   input  logic [NUM_DST-1:0]            m_rlast
);
   typedef enum logic [1:0] {R_IDLE, R_ADDR, R_DATA} rst_e;

   rst_e                st_q;
   dst_e                dst_d, dst_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [LEN_W-1:0]    len_q, cnt_q;
   logic [USER_W-1:0]   user_q;
   logic [NUM_DST-1:0]  sel;
   logic                to_err;
   logic [DATA_W-1:0]   rdata_sel;
   logic [1:0]          rresp_sel;
   logic                rlast_sel;

   dmarr_decode #(.ADDR_W(ADDR_W), .STATIC_END(STATIC_END), .DRAM_BASE(DRAM_BASE)) u_dec (
      .addr(s_araddr), .remap(cfg_remap), .dst(dst_d)
   );

   assign to_err = (dst_q == DST_NONE);

   for (genvar p = 0; p < NUM_DST; p++) begin : g_port
      assign sel[p]       = (dst_q == dst_e'(2'(p)));
      assign m_arvalid[p] = sel[p] && (st_q == R_ADDR);
      assign m_rready[p]  = sel[p] && (st_q == R_DATA) && s_rready;
   end

   always_comb begin
      rdata_sel = '0;
      rresp_sel = RESP_OKAY;
      rlast_sel = 1'b0;
      for (int p = 0; p < NUM_DST; p++)
         if (sel[p]) begin
            rdata_sel = m_rdata[p];
            rresp_sel = m_rresp[p];
            rlast_sel = m_rlast[p];
         end
   end

   assign s_arready = (st_q == R_IDLE);
   assign s_rvalid  = (st_q == R_DATA) && (to_err || |(m_rvalid & sel));
   assign s_rdata   = to_err ? '0 : rdata_sel;
   assign s_rresp   = to_err ? RESP_DECERR : rresp_sel;
   assign s_rlast   = to_err ? (cnt_q == len_q) : rlast_sel;

   assign m_araddr  = addr_q;
   assign m_arlen   = len_q;
   assign m_aruser  = user_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= R_IDLE;
         dst_q  <= DST_NONE;
         addr_q <= '0;
         len_q  <= '0;
         cnt_q  <= '0;
         user_q <= '0;
      end else begin
         case (st_q)
            R_IDLE: if (s_arvalid) begin
               dst_q  <= dst_d;
               addr_q <= s_araddr;
               len_q  <= s_arlen;
               cnt_q  <= '0;
               user_q <= (dst_d == DST_COH) ? cfg_aruser : '0;
               st_q   <= (dst_d == DST_NONE) ? R_DATA : R_ADDR;
            end
            R_ADDR: if (|(m_arready & sel)) st_q <= R_DATA;
            R_DATA: if (s_rvalid && s_rready) begin
               cnt_q <= cnt_q + 1'b1;
               if (s_rlast) st_q <= R_IDLE;
            end
            default: st_q <= R_IDLE;
         endcase
      end
   end

   // R6: one read in flight
   a_r6_ar_single: assert property (@(posedge clk) disable iff (!rst_n)
      (s_arvalid && s_arready) |=> !s_arready);
   // R10: held read address until accepted
   a_r10_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((|m_arvalid) && !(|(m_arvalid & m_arready))) |=> ($stable(m_arvalid) && $stable(m_araddr)));
   // R7: at most one destination active
   a_r7_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(m_arvalid) && $onehot0(m_rready));
   // R3: internally generated beats carry decode error and zero data
   a_r3_rd_decerr: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !(|m_rvalid)) |-> (s_rresp == RESP_DECERR && s_rdata == '0));
   // R5: no sideband on direct routes
   a_r5_aruser_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid[0] || m_arvalid[1]) |-> (m_aruser == '0));
endmodule

// File: rtl/dma_remap_router.sv
`timescale 1ns/1ps
module dma_remap_router
   import dmarr_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DATA_W     = 64,
   parameter int unsigned LEN_W      = 8,
   parameter int unsigned USER_W     = 6,
   parameter logic [63:0] STATIC_END = 64'h2000_0000,
   parameter logic [63:0] DRAM_BASE  = 64'h8000_0000,
   localparam int unsigned STRB_W    = DATA_W / 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [1:0]                     cfg_remap,
   input  logic [STRB_W-1:0]              cfg_strb_mask,
   input  logic [USER_W-1:0]              cfg_awuser,
   input  logic [USER_W-1:0]              cfg_aruser,
   input  logic                           s_awvalid,
   output logic                           s_awready,
   input  logic [ADDR_W-1:0]              s_awaddr,
   input  logic [LEN_W-1:0]               s_awlen,
   input  logic                           s_wvalid,
   output logic                           s_wready,
   input  logic [DATA_W-1:0]              s_wdata,
   input  logic [STRB_W-1:0]              s_wstrb,
   input  logic                           s_wlast,
   output logic                           s_bvalid,
   input  logic                           s_bready,
   output logic [1:0]                     s_bresp,
   input  logic                           s_arvalid,
   output logic                           s_arready,
   input  logic [ADDR_W-1:0]              s_araddr,
   input  logic [LEN_W-1:0]               s_arlen,
   output logic                           s_rvalid,
   input  logic                           s_rready,
   output logic [DATA_W-1:0]              s_rdata,
   output logic [1:0]                     s_rresp,
   output logic                           s_rlast,
   output logic [NUM_DST-1:0]             m_awvalid,
   input  logic [NUM_DST-1:0]             m_awready,
   output logic [ADDR_W-1:0]              m_awaddr,
   output logic [LEN_W-1:0]               m_awlen,
   output logic [USER_W-1:0]              m_awuser,
   output logic [NUM_DST-1:0]             m_wvalid,
   input  logic [NUM_DST-1:0]             m_wready,
   output logic [DATA_W-1:0]              m_wdata,
   output logic [STRB_W-1:0]              m_wstrb,
   output logic                           m_wlast,
   input  logic [NUM_DST-1:0]             m_bvalid,
   output logic [NUM_DST-1:0]             m_bready,
   input  logic [NUM_DST-1:0][1:0]        m_bresp,
   output logic [NUM_DST-1:0]             m_arvalid,
   input  logic [NUM_DST-1:0]             m_arready,
   output logic [ADDR_W-1:0]              m_araddr,
   output logic [LEN_W-1:0]               m_arlen,
   output logic [USER_W-1:0]              m_aruser,
   input  logic [NUM_DST-1:0]             m_rvalid,
   output logic [NUM_DST-1:0]             m_rready,
   input  logic [NUM_DST-1:0][DATA_W-1:0] m_rdata,
   input  logic [NUM_DST-1:0][1:0]        m_rresp,
   input  logic [NUM_DST-1:0]             m_rlast
);
   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be a positive multiple of 8");
   end
   if (STATIC_END > DRAM_BASE) begin : g_bad_regions
      $error("STATIC_END must not exceed DRAM_BASE");
   end
   if (ADDR_W > 64 || ADDR_W < 2) begin : g_bad_addr_w
      $error("ADDR_W out of range");
   end
   if (USER_W < 1 || LEN_W < 1) begin : g_bad_side_w
      $error("USER_W and LEN_W must be at least 1");
   end

   dmarr_wr #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .USER_W(USER_W),
      .STATIC_END(STATIC_END), .DRAM_BASE(DRAM_BASE)
   ) u_wr (
      .clk(clk), .rst_n(rst_n), .cfg_remap(cfg_remap), .cfg_strb_mask(cfg_strb_mask),
      .cfg_awuser(cfg_awuser),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_wlast(s_wlast), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
      .m_awuser(m_awuser), .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
      .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_bresp(m_bresp)
   );

   dmarr_rd #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .USER_W(USER_W),
      .STATIC_END(STATIC_END), .DRAM_BASE(DRAM_BASE)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .cfg_remap(cfg_remap), .cfg_aruser(cfg_aruser),
      .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arlen(s_arlen),
      .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
      .s_rlast(s_rlast),
      .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
      .m_aruser(m_aruser), .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
      .m_rresp(m_rresp), .m_rlast(m_rlast)
   );

   // R9: nothing forwarded while reset is being released
   a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awready && s_arready) |-> (m_awvalid == '0 && m_arvalid == '0 && !s_bvalid && !s_rvalid));
endmodule

// File: tb/dma_remap_router_tb_top.sv
`timescale 1ns/1ps
module dma_remap_router_tb_top;
   localparam int AW = 32, DW = 64, SW = 8, LW = 8, UW = 6, ND = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [1:0]  cfg_remap = '0;
   logic [SW-1:0] cfg_strb_mask = '0;
   logic [UW-1:0] cfg_awuser = '0, cfg_aruser = '0;
   logic s_awvalid = 0, s_awready;
   logic [AW-1:0] s_awaddr = '0;
   logic [LW-1:0] s_awlen = '0;
   logic s_wvalid = 0, s_wready, s_wlast = 0;
   logic [DW-1:0] s_wdata = '0;
   logic [SW-1:0] s_wstrb = '0;
   logic s_bvalid, s_bready = 0;
   logic [1:0] s_bresp;
   logic s_arvalid = 0, s_arready;
   logic [AW-1:0] s_araddr = '0;
   logic [LW-1:0] s_arlen = '0;
   logic s_rvalid, s_rready = 0, s_rlast;
   logic [DW-1:0] s_rdata;
   logic [1:0] s_rresp;
   logic [ND-1:0] m_awvalid, m_awready = '0;
   logic [AW-1:0] m_awaddr;
   logic [LW-1:0] m_awlen;
   logic [UW-1:0] m_awuser;
   logic [ND-1:0] m_wvalid, m_wready = '0;
   logic [DW-1:0] m_wdata;
   logic [SW-1:0] m_wstrb;
   logic m_wlast;
   logic [ND-1:0] m_bvalid = '0, m_bready;
   logic [ND-1:0][1:0] m_bresp = '0;
   logic [ND-1:0] m_arvalid, m_arready = '0;
   logic [AW-1:0] m_araddr;
   logic [LW-1:0] m_arlen;
   logic [UW-1:0] m_aruser;
   logic [ND-1:0] m_rvalid = '0, m_rready;
   logic [ND-1:0][DW-1:0] m_rdata = '0;
   logic [ND-1:0][1:0] m_rresp = '0;
   logic [ND-1:0] m_rlast = '0;

   dma_remap_router dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_remap(cfg_remap), .cfg_strb_mask(cfg_strb_mask),
      .cfg_awuser(cfg_awuser), .cfg_aruser(cfg_aruser),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr), .s_awlen(s_awlen),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_wlast(s_wlast), .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
      .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr), .s_arlen(s_arlen),
      .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
      .s_rlast(s_rlast),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr), .m_awlen(m_awlen),
      .m_awuser(m_awuser), .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
      .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid), .m_bready(m_bready),
      .m_bresp(m_bresp),
      .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
      .m_aruser(m_aruser), .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rdata(m_rdata),
      .m_rresp(m_rresp), .m_rlast(m_rlast)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   // expected port: 0 static, 1 DRAM, 2 coherency, 3 none (R1, R2, R3)
   function automatic int exp_port(input logic [31:0] a, input logic [1:0] rm);
      if (a < 32'h2000_0000) return rm[1] ? 2 : 0;
      if (a >= 32'h8000_0000) return rm[0] ? 2 : 1;
      return 3;
   endfunction

   function automatic logic [2:0] port_bits(input int p);
      return (p < 3) ? 3'(1 << p) : 3'b000;
   endfunction

   function automatic string tag_for(input logic [31:0] a, input int p, input bit flip);
      if (flip) return "R6";
      if (p == 3) return "R3";
      return (a < 32'h2000_0000) ? "R1" : "R2";
   endfunction

   function automatic logic [31:0] rand_addr();
      int k = $urandom_range(0, 2);
      if (k == 0) return $urandom & 32'h1FFF_FFFF;
      if (k == 1) return $urandom | 32'h8000_0000;
      return 32'h2000_0000 + ($urandom % 32'h6000_0000);
   endfunction

   task automatic wr_addr_phase(input logic [31:0] a, input logic [7:0] len, input bit flip, output int p);
      logic [5:0] exp_user;
      string t;
      int stall;
      @(negedge clk);
      p = exp_port(a, cfg_remap);
      t = tag_for(a, p, flip);
      s_awaddr = a; s_awlen = len; s_awvalid = 1'b1;
      #1;
      while (!s_awready) begin @(negedge clk); #1; end
      exp_user = (p == 2) ? cfg_awuser : 6'd0;
      @(negedge clk);
      s_awvalid = 1'b0;
      if (flip) begin cfg_remap = ~cfg_remap; cfg_awuser = ~cfg_awuser; end
      #1;
      chk("R6", "awready low while busy", 64'(s_awready), 64'd0);
      if (p < 3) begin
         stall = $urandom_range(0, 2);
         for (int i = 0; i < stall; i++) begin
            chk("R10", "awvalid held", 64'(m_awvalid), 64'(port_bits(p)));
            @(negedge clk); #1;
         end
         chk(t, "awvalid port", 64'(m_awvalid), 64'(port_bits(p)));
         chk("R10", "awaddr", 64'(m_awaddr), 64'(a));
         chk("R10", "awlen", 64'(m_awlen), 64'(len));
         chk("R5", "awuser", 64'(m_awuser), 64'(exp_user));
         m_awready[p] = 1'b1;
         @(negedge clk);
         m_awready = '0;
      end else begin
         chk("R3", "no awvalid on hole", 64'(m_awvalid), 64'd0);
      end
   endtask

   task automatic wr_data_resp(input int p, input logic [7:0] len);
      logic [63:0] d;
      logic [7:0] sb;
      logic [1:0] br;
      int q;
      for (int i = 0; i <= int'(len); i++) begin
         d = {$urandom, $urandom};
         sb = 8'($urandom);
         s_wdata = d; s_wstrb = sb; s_wlast = (i == int'(len)); s_wvalid = 1'b1;
         if (p < 3) m_wready[p] = 1'b1;
         #1;
         chk((p < 3) ? "R7" : "R3", "wready", 64'(s_wready), 64'd1);
         chk("R7", "wvalid port", 64'(m_wvalid), 64'(port_bits(p)));
         if (p < 3) begin
            chk("R4", "wstrb masked", 64'(m_wstrb), 64'(sb & ~cfg_strb_mask));
            chk("R10", "wdata", m_wdata, d);
         end
         @(negedge clk);
      end
      s_wvalid = 1'b0; s_wlast = 1'b0; m_wready = '0;
      br = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b00;
      q = (p < 3) ? (p + 1) % 3 : 0;
      if (p < 3) begin m_bvalid[p] = 1'b1; m_bresp[p] = br; end
      m_bvalid[q] = 1'b1; m_bresp[q] = 2'b01;
      s_bready = 1'b1;
      #1;
      chk((p < 3) ? "R7" : "R3", "bvalid", 64'(s_bvalid), 64'd1);
      chk((p < 3) ? "R7" : "R3", "bresp", 64'(s_bresp), 64'((p < 3) ? br : 2'b11));
      chk("R7", "bready other port", 64'(m_bready[q]), 64'd0);
      @(negedge clk);
      s_bready = 1'b0; m_bvalid = '0; m_bresp = '0;
      #1;
      chk("R6", "awready after B", 64'(s_awready), 64'd1);
   endtask

   task automatic wr_txn(input logic [31:0] a, input logic [7:0] len, input bit flip);
      int p;
      wr_addr_phase(a, len, flip, p);
      wr_data_resp(p, len);
   endtask

   task automatic rd_txn(input logic [31:0] a, input logic [7:0] len, input bit flip);
      int p, q, stall;
      logic [5:0] exp_user;
      logic [63:0] d;
      logic [1:0] rr;
      string t;
      @(negedge clk);
      p = exp_port(a, cfg_remap);
      t = tag_for(a, p, flip);
      s_araddr = a; s_arlen = len; s_arvalid = 1'b1;
      #1;
      while (!s_arready) begin @(negedge clk); #1; end
      exp_user = (p == 2) ? cfg_aruser : 6'd0;
      @(negedge clk);
      s_arvalid = 1'b0;
      if (flip) begin cfg_remap = ~cfg_remap; cfg_aruser = ~cfg_aruser; end
      #1;
      chk("R6", "arready low while busy", 64'(s_arready), 64'd0);
      if (p < 3) begin
         stall = $urandom_range(0, 2);
         for (int i = 0; i < stall; i++) begin
            chk("R10", "arvalid held", 64'(m_arvalid), 64'(port_bits(p)));
            @(negedge clk); #1;
         end
         chk(t, "arvalid port", 64'(m_arvalid), 64'(port_bits(p)));
         chk("R10", "araddr", 64'(m_araddr), 64'(a));
         chk("R10", "arlen", 64'(m_arlen), 64'(len));
         chk("R5", "aruser", 64'(m_aruser), 64'(exp_user));
         m_arready[p] = 1'b1;
         @(negedge clk);
         m_arready = '0;
      end else begin
         chk("R3", "no arvalid on hole", 64'(m_arvalid), 64'd0);
      end
      q = (p < 3) ? (p + 2) % 3 : 1;
      for (int i = 0; i <= int'(len); i++) begin
         d = {$urandom, $urandom};
         rr = ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b00;
         if (p < 3) begin
            m_rvalid[p] = 1'b1; m_rdata[p] = d; m_rresp[p] = rr; m_rlast[p] = (i == int'(len));
         end
         m_rvalid[q] = 1'b1; m_rdata[q] = ~d; m_rresp[q] = 2'b01; m_rlast[q] = 1'b1;
         s_rready = 1'b1;
         #1;
         chk((p < 3) ? "R7" : "R3", "rvalid", 64'(s_rvalid), 64'd1);
         chk((p < 3) ? "R7" : "R3", "rdata", s_rdata, (p < 3) ? d : 64'd0);
         chk((p < 3) ? "R7" : "R3", "rresp", 64'(s_rresp), 64'((p < 3) ? rr : 2'b11));
         chk((p < 3) ? "R7" : "R3", "rlast", 64'(s_rlast), 64'(i == int'(len)));
         chk("R7", "rready other port", 64'(m_rready[q]), 64'd0);
         @(negedge clk);
      end
      s_rready = 1'b0; m_rvalid = '0; m_rlast = '0; m_rresp = '0; m_rdata = '0;
      #1;
      chk("R6", "arready after last R", 64'(s_arready), 64'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not complete actual=timeout expected=done");
      report();
      $finish;
   end

   initial begin
      logic [31:0] edges [6];
      int wp;
      void'($urandom(32'd7741));
      edges[0] = 32'h0000_0000; edges[1] = 32'h1FFF_FFFF; edges[2] = 32'h2000_0000;
      edges[3] = 32'h7FFF_FFFF; edges[4] = 32'h8000_0000; edges[5] = 32'hFFFF_FFFF;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R9", "awready after reset", 64'(s_awready), 64'd1);
      chk("R9", "arready after reset", 64'(s_arready), 64'd1);
      chk("R9", "downstream valids", 64'({m_awvalid, m_arvalid, m_wvalid}), 64'd0);
      chk("R9", "response valids", 64'({s_bvalid, s_rvalid}), 64'd0);

      // region edges under all remap values (R1, R2, R3)
      for (int rm = 0; rm < 4; rm++) begin
         for (int e = 0; e < 6; e++) begin
            cfg_remap = 2'(rm);
            cfg_awuser = 6'($urandom); cfg_aruser = 6'($urandom);
            cfg_strb_mask = (e == 0) ? 8'hFF : ((e == 1) ? 8'h00 : 8'($urandom));
            wr_txn(edges[e], 8'(e % 3), 1'b0);
            rd_txn(edges[e], 8'(e % 3), 1'b0);
         end
      end

      // long decode-error read burst (R3)
      cfg_remap = 2'b00;
      rd_txn(32'h4000_0000, 8'd7, 1'b0);

      // read completes while a write waits for data (R8)
      cfg_remap = 2'b01;
      cfg_awuser = 6'h2A;
      wr_addr_phase(32'h9000_0000, 8'd1, 1'b0, wp);
      #1;
      chk("R8", "arready during write", 64'(s_arready), 64'd1);
      rd_txn(32'h0100_0000, 8'd2, 1'b0);
      chk("R8", "write still waiting for data", 64'(s_awready), 64'd0);
      wr_data_resp(wp, 8'd1);

      // constrained random mix with occasional mid-flight config changes (R6)
      for (int n = 0; n < 160; n++) begin
         cfg_remap = 2'($urandom);
         cfg_strb_mask = 8'($urandom);
         if (n % 8 == 0) cfg_strb_mask = 8'h00;
         if (n % 8 == 1) cfg_strb_mask = 8'hFF;
         cfg_awuser = 6'($urandom); cfg_aruser = 6'($urandom);
         if ($urandom_range(0, 1) != 0)
            wr_txn(rand_addr(), 8'($urandom_range(0, 3)), $urandom_range(0, 3) == 0);
         else
            rd_txn(rand_addr(), 8'($urandom_range(0, 3)), $urandom_range(0, 3) == 0);
      end

      report();
      $finish;
   end
endmodule